// File: doc/BRIEF.md
# Vector Lane Structure Access Sequencer

This block carries out single-structure lane transfers between a file of 128-bit vector registers and a byte-addressed memory. It takes a decoded instruction: a direction bit, a 3-bit opcode, a 2-bit size, the Q and S bits, the R bit and the first register number. It also takes a base address and a flag that marks the base as the stack pointer. From these fields the block works out the element width, the lane number and how many registers take part, which is one to four. It then moves one element per register through consecutive registers. The register number wraps from 31 back to 0.

The block has three transfer modes:
- A store copies one lane of each register to memory.
- A lane load writes one memory element into one lane of each register and keeps the other lanes unchanged.
- A replicate load copies one memory element into every lane of each destination register.

Illegal field combinations are rejected and no access is made. A stack-pointer base that is not 16-byte aligned ends the command with a fault flag, also without any access.

The register file and the memory sit outside the block. Both have synchronous read ports with one cycle of latency. The block drives the register read address, the register write strobe, and the memory read and write strobes from flops. Each element goes through a three-step pipeline: request, data return, write. Successive elements overlap in this pipeline, so a command makes one memory access per cycle until it is finished.

Top module: `simd_lane_seq`

## Requirements
- R1: After reset, busy, done, undef, align_fault, mem_re, mem_we and vreg_we are all low.
- R2: The number of registers is the 2-bit value {opcode[0], R} plus one. Element k uses register (Rt + k) mod 32, so Rt = 30 with four registers touches 30, 31, 0, 1.
- R3: opcode[2:1] = 00 moves a byte. The lane is the 4-bit value {Q, S, size}, which gives lanes 0 to 15.
- R4: opcode[2:1] = 01 moves a 16-bit halfword. The lane is {Q, S, size[1]}. If size[0] = 1 the encoding is undefined.
- R5: opcode[2:1] = 10 is undefined if size[1] = 1. With size = 00 it moves a 32-bit word in lane {Q, S}. With size = 01 it moves a 64-bit doubleword in lane Q, and S = 1 is undefined.
- R6: opcode[2:1] = 11 is a replicate load with an element of 8 << size bits. It is undefined when L = 0 (store) or S = 1. The element fills every lane of bits [63:0] when Q = 0 and of bits [127:0] when Q = 1. When Q = 0, bits [127:64] are cleared.
- R7: Element k is at byte address base + k * (element bytes). Bytes are little-endian.
- R8: In a store (L = 0), the selected lane of each register is written to memory. No register is written.
- R9: A lane load (L = 1, opcode[2:1] not 11) replaces only the selected lane of each destination register. All other bits are kept.
- R10: An undefined encoding raises undef for one cycle together with done. It makes no memory access and no register write.
- R11: When base_is_sp is high and base_addr[3:0] is not zero, align_fault and done pulse for one cycle and no access is made. A misaligned base that is not the stack pointer runs normally. Undefined encodings take priority over this check.
- R12: At most one memory access happens per cycle. A command's accesses occur on consecutive cycles. busy is high while the command runs, and done is a single-cycle pulse at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; accepted when the block is idle |
| enc_q | input | 1 | Q bit: 128-bit register width and top lane bit |
| enc_l | input | 1 | 1 = load, 0 = store |
| enc_r | input | 1 | Low bit of the register count |
| enc_s | input | 1 | S bit of the lane index |
| enc_opcode | input | 3 | [2:1] element scale, [0] high bit of the register count |
| enc_size | input | 2 | Size field |
| enc_rt | input | 5 | First register number |
| base_is_sp | input | 1 | Base address comes from the stack pointer |
| base_addr | input | AW | Byte base address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| undef | output | 1 | Undefined encoding pulse |
| align_fault | output | 1 | Stack-pointer misalignment pulse |
| vreg_raddr | output | 5 | Register file read address |
| vreg_rdata | input | 128 | Register file read data, one cycle after address |
| vreg_we | output | 1 | Register file write strobe |
| vreg_waddr | output | 5 | Register file write address |
| vreg_wdata | output | 128 | Register file write data |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | log2 of access byte count |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 64 | Store data, element in the low bits |
| mem_rdata | input | 64 | Load data, one cycle after request, element in the low bits |

## Verification
The bench sweeps all 512 combinations of the scale, size, Q, S, L, R and opcode[0] fields. The first register and the base address vary from one command to the next, and some commands use the stack-pointer flag.

The sweep covers several distinct situations:
- Byte, halfword, word and doubleword lanes at every legal index, which shows whether the lane offset arithmetic is right.
- Stores against lane loads, which shows whether the other lanes of a register are preserved and whether a store leaves the registers alone.
- Replicate loads with Q = 0 and Q = 1, which isolate the upper-half clearing.
- Stack-pointer bases that are aligned, misaligned, or misaligned with an undefined encoding, which show the precedence of the two rejection paths.
- Register counts that run past register 31, which show the wrap.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       undef;
    logic [1:0] esz;    // log2 of element bytes
    logic [3:0] lane;
    logic       repl;
    logic [2:0] count;  // registers, 1..4
  } dec_t;

endpackage

// File: rtl/simd_lane_decode.sv
module simd_lane_decode
  import simd_lane_pkg::*;
(
  input  logic       q,
  input  logic       l,
  input  logic       r,
  input  logic       s,
  input  logic [2:0] opcode,
  input  logic [1:0] size,
  output dec_t       dec
);

  always_comb begin
    dec       = '0;
    dec.count = {1'b0, opcode[0], r} + 3'd1;
    case (opcode[2:1])
      2'b00: begin
        dec.esz  = 2'd0;
        dec.lane = {q, s, size};
      end
      2'b01: begin
        dec.esz   = 2'd1;
        dec.lane  = {1'b0, q, s, size[1]};
        dec.undef = size[0];
      end
      2'b10: begin
        dec.undef = size[1] | (size[0] & s);
        if (!size[0]) begin
          dec.esz  = 2'd2;
          dec.lane = {2'b00, q, s};
        end else begin
          dec.esz  = 2'd3;
          dec.lane = {3'b000, q};
        end
      end
      default: begin
        dec.esz   = size;
        dec.repl  = 1'b1;
        dec.undef = ~l | s;
      end
    endcase
  end

endmodule

// File: rtl/simd_lane_issue.sv
module simd_lane_issue #(
  parameter int AW   = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            step,
  input  logic [AW-1:0]   base,
  input  logic [RIDX-1:0] rt,
  input  logic [1:0]      esz,
  input  logic [2:0]      count,
  output logic [RIDX-1:0] elem_reg,
  output logic [AW-1:0]   elem_addr,
  output logic            last
);

  logic [1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clear) idx <= 2'd0;
    else if (step)    idx <= idx + 2'd1;
  end

  always_comb begin
    elem_reg  = rt + RIDX'(idx);
    elem_addr = base + (AW'(idx) << esz);
    last      = step && ({1'b0, idx} == (count - 3'd1));
  end

endmodule

// File: rtl/simd_lane_data.sv
module simd_lane_data #(
  parameter int VW = 128,
  parameter int EW = 64
) (
  input  logic [VW-1:0] old_reg,
  input  logic [EW-1:0] mem_word,
  input  logic [1:0]    esz,
  input  logic [3:0]    lane,
  input  logic          repl,
  input  logic          wide,
  output logic [EW-1:0] st_elem,
  output logic [VW-1:0] ld_reg
);

  logic [VW-1:0] rep [4];
  logic [VW-1:0] ext, ins, mwide, rsel;
  logic [EW-1:0] emask;
  logic [7:0]    sh;

  for (genvar g = 0; g < 4; g++) begin : g_rep
    localparam int EB = 8 << g;
    assign rep[g] = {(VW/EB){mem_word[EB-1:0]}};
  end

  always_comb begin
    case (esz)
      2'd0:    emask = EW'(8'hFF);
      2'd1:    emask = EW'(16'hFFFF);
      2'd2:    emask = EW'(32'hFFFF_FFFF);
      default: emask = '1;
    endcase
    sh      = 8'({lane, 3'b000}) << esz;
    ext     = old_reg >> sh;
    st_elem = ext[EW-1:0] & emask;
    mwide   = VW'(emask) << sh;
    ins     = (old_reg & ~mwide) | (VW'(mem_word & emask) << sh);
    rsel    = wide ? rep[esz] : {{(VW/2){1'b0}}, rep[esz][VW/2-1:0]};
    ld_reg  = repl ? rsel : ins;
  end

endmodule

// File: rtl/simd_lane_seq.sv
module simd_lane_seq
  import simd_lane_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 32,
  parameter int VW   = 128,
  parameter int EW   = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     enc_q,
  input  logic                     enc_l,
  input  logic                     enc_r,
  input  logic                     enc_s,
  input  logic [2:0]               enc_opcode,
  input  logic [1:0]               enc_size,
  input  logic [$clog2(NREG)-1:0]  enc_rt,
  input  logic                     base_is_sp,
  input  logic [AW-1:0]            base_addr,
  output logic                     busy,
  output logic                     done,
  output logic                     undef,
  output logic                     align_fault,
  output logic [$clog2(NREG)-1:0]  vreg_raddr,
  input  logic [VW-1:0]            vreg_rdata,
  output logic                     vreg_we,
  output logic [$clog2(NREG)-1:0]  vreg_waddr,
  output logic [VW-1:0]            vreg_wdata,
  output logic [AW-1:0]            mem_addr,
  output logic [1:0]               mem_size,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic [EW-1:0]            mem_wdata,
  input  logic [EW-1:0]            mem_rdata
);

  localparam int RIDX = $clog2(NREG);

  dec_t       dec;
  seq_state_t state;
  logic       accept, misal, go, step, last;

  logic [AW-1:0]   c_base;
  logic [RIDX-1:0] c_rt;
  logic [1:0]      c_esz;
  logic [3:0]      c_lane;
  logic [2:0]      c_count;
  logic            c_repl, c_wide, c_load;

  logic [RIDX-1:0] elem_reg;
  logic [AW-1:0]   elem_addr;

  logic            s1_vld, s1_last, s2_vld, s2_last;
  logic [RIDX-1:0] s1_reg, s2_reg;
  logic [AW-1:0]   s1_addr, s2_addr;

  logic [EW-1:0]   st_elem;
  logic [VW-1:0]   ld_reg;

  simd_lane_decode u_dec (
    .q(enc_q), .l(enc_l), .r(enc_r), .s(enc_s),
    .opcode(enc_opcode), .size(enc_size), .dec(dec)
  );

  assign accept = start && (state == ST_IDLE);
  assign misal  = base_is_sp && (base_addr[3:0] != 4'd0);
  assign go     = accept && !dec.undef && !misal;
  assign step   = (state == ST_ISSUE);

  simd_lane_issue #(.AW(AW), .RIDX(RIDX)) u_issue (
    .clk(clk), .rst(rst), .clear(go), .step(step),
    .base(c_base), .rt(c_rt), .esz(c_esz), .count(c_count),
    .elem_reg(elem_reg), .elem_addr(elem_addr), .last(last)
  );

  simd_lane_data #(.VW(VW), .EW(EW)) u_data (
    .old_reg(vreg_rdata), .mem_word(mem_rdata), .esz(c_esz),
    .lane(c_lane), .repl(c_repl), .wide(c_wide),
    .st_elem(st_elem), .ld_reg(ld_reg)
  );

  // command latch and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      c_base  <= '0;
      c_rt    <= '0;
      c_esz   <= '0;
      c_lane  <= '0;
      c_count <= '0;
      c_repl  <= 1'b0;
      c_wide  <= 1'b0;
      c_load  <= 1'b0;
    end else begin
      if (go) begin
        c_base  <= base_addr;
        c_rt    <= enc_rt;
        c_esz   <= dec.esz;
        c_lane  <= dec.lane;
        c_count <= dec.count;
        c_repl  <= dec.repl;
        c_wide  <= enc_q;
        c_load  <= enc_l;
      end
      if (go)           busy <= 1'b1;
      else if (s2_last) busy <= 1'b0;
      case (state)
        ST_IDLE:  if (go)      state <= ST_ISSUE;
        ST_ISSUE: if (last)    state <= ST_DRAIN;
        ST_DRAIN: if (s2_last) state <= ST_IDLE;
        default:               state <= ST_IDLE;
      endcase
    end
  end

  // request, data-return and write stages
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld      <= 1'b0;
      s1_last     <= 1'b0;
      s1_reg      <= '0;
      s1_addr     <= '0;
      s2_vld      <= 1'b0;
      s2_last     <= 1'b0;
      s2_reg      <= '0;
      s2_addr     <= '0;
      vreg_raddr  <= '0;
      vreg_we     <= 1'b0;
      vreg_waddr  <= '0;
      vreg_wdata  <= '0;
      mem_addr    <= '0;
      mem_size    <= '0;
      mem_re      <= 1'b0;
      mem_we      <= 1'b0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      undef       <= 1'b0;
      align_fault <= 1'b0;
    end else begin
      s1_vld     <= step;
      s1_last    <= last;
      s1_reg     <= elem_reg;
      s1_addr    <= elem_addr;
      vreg_raddr <= elem_reg;
      mem_re     <= step && c_load;
      if (go) mem_size <= dec.esz;

      s2_vld  <= s1_vld;
      s2_last <= s1_last;
      s2_reg  <= s1_reg;
      s2_addr <= s1_addr;

      vreg_we    <= s2_vld && c_load;
      vreg_waddr <= s2_reg;
      vreg_wdata <= ld_reg;
      mem_we     <= s2_vld && !c_load;
      mem_wdata  <= st_elem;

      if (step && c_load)         mem_addr <= elem_addr;
      else if (s2_vld && !c_load) mem_addr <= s2_addr;

      undef       <= accept && dec.undef;
      align_fault <= accept && !dec.undef && misal;
      done        <= s2_last || (accept && (dec.undef || misal));
    end
  end

endmodule

// File: rtl/simd_lane_seq_chk.sv
module simd_lane_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic undef,
  input logic align_fault,
  input logic mem_re,
  input logic mem_we,
  input logic vreg_we
);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R12
  AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R12
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> busy); // R12
  AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (rst)
    undef |-> (done && !mem_re && !mem_we && !vreg_we)); // R10
  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (done && !undef && !mem_re && !mem_we && !vreg_we)); // R11
  AST_STORE_NO_VWRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !vreg_we); // R8

endmodule

bind simd_lane_seq simd_lane_seq_chk u_chk (.*);

// File: tb/simd_lane_seq_bench.sv
module simd_lane_seq_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         enc_q = 0, enc_l = 0, enc_r = 0, enc_s = 0;
  logic [2:0]   enc_opcode = '0;
  logic [1:0]   enc_size = '0;
  logic [4:0]   enc_rt = '0;
  logic         base_is_sp = 1'b0;
  logic [31:0]  base_addr = '0;
  logic         busy, done, undef, align_fault;
  logic [4:0]   vreg_raddr, vreg_waddr;
  logic [127:0] vreg_rdata, vreg_wdata;
  logic         vreg_we, mem_re, mem_we;
  logic [31:0]  mem_addr;
  logic [1:0]   mem_size;
  logic [63:0]  mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [127:0] vregs [32];
  logic [7:0]   memb  [256];

  always #10 clk = ~clk;

  simd_lane_seq u_simd_lane_seq (.*);

  // external register file and memory models
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++)
        for (int k = 0; k < 16; k++)
          vregs[i][8*k +: 8] <= 8'(i*16 + k) ^ 8'h5A;
      for (int a = 0; a < 256; a++) memb[a] <= 8'(a*37 + 11);
      vreg_rdata <= '0;
      mem_rdata  <= '0;
    end else begin
      if (vreg_we) vregs[vreg_waddr] <= vreg_wdata;
      if (mem_we)
        for (int j = 0; j < (1 << mem_size); j++)
          memb[8'(mem_addr[7:0] + 8'(j))] <= mem_wdata[8*j +: 8];
      vreg_rdata <= vregs[vreg_raddr];
      for (int j = 0; j < 8; j++)
        mem_rdata[8*j +: 8] <= memb[8'(mem_addr[7:0] + 8'(j))];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string scale_tag(input logic [1:0] sc);
    case (sc)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // reference decode written from the requirements
  task automatic ref_decode(input logic q, l, r, s, input logic [2:0] op, input logic [1:0] sz,
                            output bit und, output int esz, output int lane, output bit repl, output int cnt);
    cnt = int'({op[0], r}) + 1;
    und = 0; repl = 0; lane = 0; esz = 0;
    case (op[2:1])
      2'b00: begin esz = 0; lane = int'({q, s, sz}); end
      2'b01: begin esz = 1; lane = int'({q, s, sz[1]}); und = sz[0]; end
      2'b10: begin
        if (sz[1]) und = 1;
        if (!sz[0]) begin esz = 2; lane = int'({q, s}); end
        else begin esz = 3; lane = int'(q); if (s) und = 1; end
      end
      default: begin esz = int'(sz); repl = 1; und = !l || s; end
    endcase
  endtask

  task automatic run_cmd(input logic q, l, r, s, input logic [2:0] op, input logic [1:0] sz,
                         input logic [4:0] rt, input logic sp, input logic [31:0] base);
    logic [127:0] exp_v [32];
    logic [7:0]   exp_m [256];
    bit und, repl, flt, ok, seen_u, seen_f, got;
    int esz, lane, cnt, eb, acc, first, lastc, rn, a, nb;
    string st, vt, mt;
    logic [127:0] act_v, want_v;

    ref_decode(q, l, r, s, op, sz, und, esz, lane, repl, cnt);
    flt = !und && sp && (base[3:0] != 4'd0);
    ok  = !und && !flt;
    eb  = 1 << esz;
    st  = scale_tag(op[2:1]);
    for (int i = 0; i < 32; i++)  exp_v[i] = vregs[i];
    for (int i = 0; i < 256; i++) exp_m[i] = memb[i];
    if (ok) begin
      for (int k = 0; k < cnt; k++) begin
        rn = (int'(rt) + k) % 32;
        a  = int'(base[7:0]) + k*eb;
        if (!l) begin
          for (int j = 0; j < eb; j++)
            exp_m[(a + j) % 256] = exp_v[rn][lane*eb*8 + 8*j +: 8];
        end else if (!repl) begin
          for (int j = 0; j < eb; j++)
            exp_v[rn][lane*eb*8 + 8*j +: 8] = exp_m[(a + j) % 256];
        end else begin
          nb = q ? 16 : 8;
          for (int p = 0; p < 16; p++)
            exp_v[rn][8*p +: 8] = (p < nb) ? exp_m[(a + (p % eb)) % 256] : 8'h00;
        end
      end
    end

    @(negedge clk);
    enc_q = q; enc_l = l; enc_r = r; enc_s = s; enc_opcode = op; enc_size = sz;
    enc_rt = rt; base_is_sp = sp; base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc = 0; first = 0; lastc = 0; seen_u = 0; seen_f = 0; got = 0;
    for (int k = 0; k < 40; k++) begin
      if (mem_re || mem_we) begin
        if (acc == 0) first = k;
        lastc = k;
        acc++;
      end
      if (undef) seen_u = 1;
      if (align_fault) seen_f = 1;
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R12 done never seen", 128'(got), 128'(1));
    chk(seen_u == und, "R10 undef flag", 128'(seen_u), 128'(und));
    chk(seen_f == flt, "R11 align_fault flag", 128'(seen_f), 128'(flt));
    chk(acc == (ok ? cnt : 0), "R12 access count", 128'(acc), 128'(ok ? cnt : 0));
    chk(acc == 0 || (lastc - first + 1) == acc, "R12 accesses not consecutive",
        128'(lastc - first + 1), 128'(acc));
    @(negedge clk);
    chk(!done && !busy, "R12 done pulse width", 128'({busy, done}), 128'(0));

    if (!ok)        begin vt = und ? "R10 regs" : "R11 regs"; mt = und ? "R10 mem" : "R11 mem"; end
    else if (!l)    begin vt = {st, " R8 regs"}; mt = {st, " R7 R8 mem"}; end
    else if (repl)  begin vt = "R6 R2 replicate regs"; mt = "R6 mem"; end
    else            begin vt = {st, " R2 R9 lane regs"}; mt = {st, " R7 mem"}; end

    act_v = '0; want_v = '0;
    for (int i = 0; i < 32; i++)
      if (vregs[i] !== exp_v[i] && act_v == '0 && want_v == '0) begin
        act_v = vregs[i]; want_v = exp_v[i];
      end
    chk(act_v == want_v, vt, act_v, want_v);
    act_v = '0; want_v = '0;
    for (int i = 0; i < 256; i++)
      if (memb[i] !== exp_m[i] && act_v == '0 && want_v == '0) begin
        act_v = {88'(i), 8'h00, 24'h0, memb[i]}; want_v = {88'(i), 8'h00, 24'h0, exp_m[i]};
      end
    chk(act_v == want_v, mt, act_v, want_v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, undef, align_fault, mem_re, mem_we, vreg_we} == 7'b0, "R1 reset outputs",
        128'({busy, done, undef, align_fault, mem_re, mem_we, vreg_we}), 128'(0));

    // R2: four words loaded into registers 30, 31, 0, 1, lane 3
    run_cmd(1, 1, 1, 1, 3'b101, 2'b00, 5'd30, 0, 32'd40);
    // R2: four doubleword stores wrapping past register 31
    run_cmd(1, 0, 1, 0, 3'b101, 2'b01, 5'd29, 0, 32'd100);
    // R11: aligned stack-pointer base runs, misaligned one faults
    run_cmd(0, 1, 0, 0, 3'b000, 2'b11, 5'd4, 1, 32'd64);
    run_cmd(0, 1, 0, 0, 3'b000, 2'b11, 5'd4, 1, 32'd66);
    // R11: undefined encoding wins over misaligned stack pointer
    run_cmd(0, 0, 0, 0, 3'b110, 2'b00, 5'd4, 1, 32'd66);
    // R6: replicate halfword with Q = 0 and Q = 1
    run_cmd(0, 1, 1, 0, 3'b110, 2'b01, 5'd8, 0, 32'd17);
    run_cmd(1, 1, 1, 0, 3'b110, 2'b01, 5'd8, 0, 32'd17);

    // sweep over every encoding field combination
    for (int c = 0; c < 512; c++) begin
      logic [8:0] cb;
      cb = 9'(c);
      run_cmd(cb[0], cb[2], cb[3], cb[1], {cb[8:7], cb[4]}, cb[6:5], 5'((c*7) % 32),
              (c % 3) == 0, 32'((c*13) % 220));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule